// File: doc/BRIEF.md
# Instruction Byte Parser

The parser takes a variable-length instruction one byte at a time and splits it into its parts. Each byte is offered with `in_valid` and taken while `in_ready` is high. Bytes of value 0x66 and 0x67 are size-override prefixes. In 64-bit mode, bytes 0x40 to 0x4F form a width prefix that carries four register-extension bits. After the prefixes come an optional escape sequence that picks the opcode map, the opcode byte, an optional operand-form byte, an optional scaled-index byte, a displacement and an immediate.

A small built-in attribute table sets two things for each opcode: whether an operand-form byte follows, and the immediate class (none, one byte, or operand-size dependent). The operand-form byte decides the addressing bytes as they arrive. When the final byte is taken, the parser pulses `done` for one cycle together with the byte count and every captured field. It then goes back to looking for prefixes.

If an opcode is missing from the table, if a 0xC7 opcode carries a non-zero middle field, or if the instruction runs past 15 bytes, the parser pulses `err` instead of `done` and starts the next instruction fresh.

Top module: `ibyte_parser`

## Requirements
- R1: Byte 0x66 in prefix position sets `osz` and byte 0x67 sets `asz`. Either may repeat, and every prefix byte counts toward `len`. `asz` is only reported and does not change the byte layout.
- R2: When `mode64` is 1, a prefix-position byte 0x4y sets `wpfx_seen` and loads `wpfx` = y, with W in bit 3. When `mode64` is 0, such a byte is a one-byte map-0 opcode with no further bytes, and `wpfx_seen` stays 0. `mode64` must be held steady for the whole of an instruction.
- R3: Escape 0x0F gives map 1, 0x0F 0x38 gives map 2, 0x0F 0x3A gives map 3, and any other opcode byte is map 0.
- R4: The operand-form byte splits as mode[7:6], middle[5:3], low[2:0]. A scaled-index byte (base in bits 2:0) follows it when mode is not 11 and low is 100.
- R5: Displacement length is 1 byte for mode 01 and 4 bytes for mode 10. Mode 00 with low 101 gives 4 bytes and sets `ip_rel` only when `mode64` is 1. Mode 00 with a scaled-index base of 101 gives 4 bytes. Bytes fill `disp` from the least significant byte up.
- R6: A byte-class immediate is 1 byte. A size-class immediate is 2 bytes when `osz` is set and W is not, and 4 bytes otherwise. Immediate bytes come after the displacement and fill `imm` from the least significant byte up.
- R7: `done` is high for the one cycle after the clock edge that takes the final byte. `len` gives the total byte count. All fields hold until the first byte of the next instruction is taken.
- R8: An opcode outside the table pulses `err` with `len` = bytes taken so far, gives no `done`, and the very next byte is treated as a new instruction.
- R9: Opcode 0xC7 with a middle field other than 000 pulses `err` when the operand-form byte is taken.
- R10: If byte 15 is taken and the instruction is still incomplete, `err` pulses with `len` = 15. An instruction of exactly 15 bytes completes normally.
- R11: `in_ready` goes high after reset and stays high. Cycles with `in_valid` low change no state.
- R12: During and right after reset, `done`, `err` and `in_ready` are 0.
- R13: Attribute table. Map 0: 0x01, 0x89 and 0x8B take an operand-form byte and no immediate. 0x80 and 0x83 take an operand-form byte and a byte immediate. 0xC7 takes an operand-form byte and a size-class immediate. 0x05 takes a size-class immediate only. 0x6A takes a byte immediate only. 0x90, 0xC3 and 0x40–0x4F take nothing. Map 1: 0xAF and 0x1F take an operand-form byte. Map 2: 0x00 takes an operand-form byte. Map 3: 0x0F takes an operand-form byte and a byte immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | 64-bit mode select |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser takes a byte |
| done | output | 1 | Instruction complete pulse |
| err | output | 1 | Parse error pulse |
| len | output | 4 | Bytes in the finished or aborted instruction |
| map | output | 2 | Opcode map number |
| osz | output | 1 | Operand-size prefix seen |
| asz | output | 1 | Address-size prefix seen |
| wpfx_seen | output | 1 | Width prefix seen |
| wpfx | output | 4 | Width prefix bits W,R,X,B (3..0) |
| opcode | output | 8 | Opcode byte |
| form_seen | output | 1 | Operand-form byte present |
| form | output | 8 | Operand-form byte |
| sxb_seen | output | 1 | Scaled-index byte present |
| sxb | output | 8 | Scaled-index byte |
| disp_len | output | 3 | Displacement bytes |
| disp | output | 32 | Displacement value |
| imm_len | output | 3 | Immediate bytes |
| imm | output | 32 | Immediate value |
| ip_rel | output | 1 | Instruction-pointer-relative form |

## Verification
`done` or `err` for an instruction appears in exactly the cycle that follows the rising edge that takes its last byte, or the byte that causes the fault. The fields are already valid in that cycle. The driver changes inputs at the falling edge, and the monitor samples outputs at the falling edge, one half period after the edge that registered them. Each pulse is matched in order against the queued prediction, so a pulse that comes one cycle early or late shows up as a mismatch or an unexpected item. Field hold is checked several idle cycles after completion.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
  typedef enum logic [2:0] {S_PFX, S_ESC, S_ESC2, S_FORM, S_SXB, S_DISP, S_IMM} state_t;
  typedef enum logic [1:0] {IC_NONE, IC_BYTE, IC_Z} icls_t;
  typedef struct packed {
    logic  known;
    logic  has_form;
    logic  reg0;
    icls_t cls;
  } opattr_t;

  function automatic opattr_t op_lookup(input logic [1:0] mp, input logic [7:0] op);
    opattr_t a;
    a = '{known: 1'b0, has_form: 1'b0, reg0: 1'b0, cls: IC_NONE};
    case (mp)
      2'd0: begin
        if (op[7:4] == 4'h4) a = '{known: 1'b1, has_form: 1'b0, reg0: 1'b0, cls: IC_NONE};
        else case (op)
          8'h01, 8'h89, 8'h8B: a = '{known: 1'b1, has_form: 1'b1, reg0: 1'b0, cls: IC_NONE};
          8'h80, 8'h83:        a = '{known: 1'b1, has_form: 1'b1, reg0: 1'b0, cls: IC_BYTE};
          8'hC7:               a = '{known: 1'b1, has_form: 1'b1, reg0: 1'b1, cls: IC_Z};
          8'h05:               a = '{known: 1'b1, has_form: 1'b0, reg0: 1'b0, cls: IC_Z};
          8'h6A:               a = '{known: 1'b1, has_form: 1'b0, reg0: 1'b0, cls: IC_BYTE};
          8'h90, 8'hC3:        a = '{known: 1'b1, has_form: 1'b0, reg0: 1'b0, cls: IC_NONE};
          default: ;
        endcase
      end
      2'd1: if (op == 8'hAF || op == 8'h1F)
              a = '{known: 1'b1, has_form: 1'b1, reg0: 1'b0, cls: IC_NONE};
      2'd2: if (op == 8'h00)
              a = '{known: 1'b1, has_form: 1'b1, reg0: 1'b0, cls: IC_NONE};
      default: if (op == 8'h0F)
              a = '{known: 1'b1, has_form: 1'b1, reg0: 1'b0, cls: IC_BYTE};
    endcase
    return a;
  endfunction
endpackage

// File: rtl/ibp_optable.sv
module ibp_optable
  import ibp_pkg::*;
(
  input  logic [1:0] mp,
  input  logic [7:0] op,
  output opattr_t    attr
);
  always_comb attr = op_lookup(mp, op);
endmodule

// File: rtl/ibp_addr.sv
module ibp_addr #(
  parameter int DLW = 3,
  parameter int NB  = 4
) (
  input  logic [1:0]     mode,
  input  logic [2:0]     low,
  input  logic [2:0]     base,
  input  logic           mode64,
  output logic           need_sxb,
  output logic [DLW-1:0] dlen,
  output logic           iprel
);
  always_comb begin
    need_sxb = (mode != 2'b11) && (low == 3'b100);
    iprel    = 1'b0;
    dlen     = '0;
    case (mode)
      2'b01: dlen = DLW'(1);
      2'b10: dlen = DLW'(NB);
      2'b00: begin
        if (low == 3'b101) begin
          dlen  = DLW'(NB);
          iprel = mode64;
        end else if (low == 3'b100 && base == 3'b101) begin
          dlen = DLW'(NB);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ibp_immsize.sv
module ibp_immsize
  import ibp_pkg::*;
#(
  parameter int DLW = 3,
  parameter int NB  = 4
) (
  input  icls_t          cls,
  input  logic           osz,
  input  logic           wide,
  output logic [DLW-1:0] ilen
);
  always_comb begin
    case (cls)
      IC_BYTE: ilen = DLW'(1);
      IC_Z:    ilen = (osz && !wide) ? DLW'(NB / 2) : DLW'(NB);
      default: ilen = '0;
    endcase
  end
endmodule

// File: rtl/ibyte_parser.sv
module ibyte_parser
  import ibp_pkg::*;
#(
  parameter int MAX_LEN = 15,
  parameter int DW      = 32,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int NB     = DW / 8,
  localparam int FW     = $clog2(NB),
  localparam int DLW    = FW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode64,
  input  logic           in_valid,
  input  logic [7:0]     in_byte,
  output logic           in_ready,
  output logic           done,
  output logic           err,
  output logic [LW-1:0]  len,
  output logic [1:0]     map,
  output logic           osz,
  output logic           asz,
  output logic           wpfx_seen,
  output logic [3:0]     wpfx,
  output logic [7:0]     opcode,
  output logic           form_seen,
  output logic [7:0]     form,
  output logic           sxb_seen,
  output logic [7:0]     sxb,
  output logic [DLW-1:0] disp_len,
  output logic [DW-1:0]  disp,
  output logic [DLW-1:0] imm_len,
  output logic [DW-1:0]  imm,
  output logic           ip_rel
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_i = rs_q[1];

  state_t         st_q, st_n;
  logic [LW-1:0]  cnt_q, cnt_n, len_q, len_n, nb;
  logic [FW-1:0]  fc_q, fc_n;
  logic [1:0]     map_q, map_n, map_sel;
  logic           osz_q, osz_n, asz_q, asz_n, ws_q, ws_n, fs_q, fs_n, ss_q, ss_n;
  logic           ipr_q, ipr_n, r0_q, r0_n, rdy_q, done_q, done_n, err_q, err_n;
  logic [3:0]     wp_q, wp_n;
  logic [7:0]     opc_q, opc_n, form_q, form_n, sxb_q, sxb_n;
  logic [DLW-1:0] dl_q, dl_n, il_q, il_n, a_dlen, i_len;
  logic [DW-1:0]  disp_q, disp_n, imm_q, imm_n;
  logic           acc, fresh, fin, bad, op_take, after_addr, after_disp;
  logic           a_sxb, a_ipr;
  opattr_t        attr;

  assign acc   = in_valid && rdy_q;
  assign fresh = (st_q == S_PFX) && (cnt_q == '0);
  assign nb    = cnt_q + LW'(1);
  assign map_sel = (st_q == S_ESC) ? 2'd1 : (st_q == S_ESC2) ? map_q : 2'd0;

  ibp_optable u_tab (.mp(map_sel), .op(in_byte), .attr(attr));

  ibp_addr #(.DLW(DLW), .NB(NB)) u_addr (
    .mode    ((st_q == S_SXB) ? form_q[7:6] : in_byte[7:6]),
    .low     ((st_q == S_SXB) ? form_q[2:0] : in_byte[2:0]),
    .base    (in_byte[2:0]),
    .mode64  (mode64),
    .need_sxb(a_sxb),
    .dlen    (a_dlen),
    .iprel   (a_ipr)
  );

  ibp_immsize #(.DLW(DLW), .NB(NB)) u_imm (
    .cls (attr.cls),
    .osz (osz_q && !fresh),
    .wide(ws_q && wp_q[3] && !fresh),
    .ilen(i_len)
  );

  always_comb begin
    st_n = st_q;  cnt_n = cnt_q;  fc_n = fc_q;  len_n = len_q;  map_n = map_q;
    osz_n = osz_q;  asz_n = asz_q;  ws_n = ws_q;  wp_n = wp_q;  opc_n = opc_q;
    fs_n = fs_q;  form_n = form_q;  ss_n = ss_q;  sxb_n = sxb_q;  r0_n = r0_q;
    dl_n = dl_q;  disp_n = disp_q;  il_n = il_q;  imm_n = imm_q;  ipr_n = ipr_q;
    done_n = 1'b0;  err_n = 1'b0;
    fin = 1'b0;  bad = 1'b0;  op_take = 1'b0;  after_addr = 1'b0;  after_disp = 1'b0;
    if (acc) begin
      if (fresh) begin
        map_n = '0;  osz_n = 1'b0;  asz_n = 1'b0;  ws_n = 1'b0;  wp_n = '0;
        opc_n = '0;  fs_n = 1'b0;  form_n = '0;  ss_n = 1'b0;  sxb_n = '0;
        dl_n = '0;  disp_n = '0;  il_n = '0;  imm_n = '0;  ipr_n = 1'b0;  r0_n = 1'b0;
      end
      cnt_n = nb;
      case (st_q)
        S_PFX: begin
          if (in_byte == 8'h66) osz_n = 1'b1;
          else if (in_byte == 8'h67) asz_n = 1'b1;
          else if (mode64 && in_byte[7:4] == 4'h4) begin
            ws_n = 1'b1;
            wp_n = in_byte[3:0];
          end else if (in_byte == 8'h0F) begin
            st_n  = S_ESC;
            map_n = 2'd1;
          end else op_take = 1'b1;
        end
        S_ESC: begin
          if (in_byte == 8'h38)      begin map_n = 2'd2; st_n = S_ESC2; end
          else if (in_byte == 8'h3A) begin map_n = 2'd3; st_n = S_ESC2; end
          else op_take = 1'b1;
        end
        S_ESC2: op_take = 1'b1;
        S_FORM: begin
          form_n = in_byte;
          bad    = r0_q && (in_byte[5:3] != 3'b000);
          dl_n   = a_dlen;
          ipr_n  = a_ipr;
          if (a_sxb) st_n = S_SXB;
          else       after_addr = 1'b1;
        end
        S_SXB: begin
          sxb_n = in_byte;
          ss_n  = 1'b1;
          dl_n  = a_dlen;
          after_addr = 1'b1;
        end
        S_DISP: begin
          disp_n[8*fc_q +: 8] = in_byte;
          if (({1'b0, fc_q} + DLW'(1)) == dl_q) begin
            fc_n = '0;
            after_disp = 1'b1;
          end else fc_n = fc_q + FW'(1);
        end
        default: begin
          imm_n[8*fc_q +: 8] = in_byte;
          if (({1'b0, fc_q} + DLW'(1)) == il_q) begin
            fc_n = '0;
            fin  = 1'b1;
          end else fc_n = fc_q + FW'(1);
        end
      endcase
      if (op_take) begin
        opc_n = in_byte;
        if (!attr.known) bad = 1'b1;
        else begin
          il_n = i_len;
          r0_n = attr.reg0;
          if (attr.has_form) begin
            fs_n = 1'b1;
            st_n = S_FORM;
          end else if (i_len != '0) st_n = S_IMM;
          else fin = 1'b1;
        end
      end
      if (after_addr) begin
        if (dl_n != '0)      st_n = S_DISP;
        else if (il_q != '0) st_n = S_IMM;
        else                 fin = 1'b1;
      end
      if (after_disp) begin
        if (il_q != '0) st_n = S_IMM;
        else            fin = 1'b1;
      end
      if (bad || (!fin && nb == LW'(MAX_LEN))) begin
        err_n = 1'b1;  len_n = nb;  st_n = S_PFX;  cnt_n = '0;  fc_n = '0;
      end else if (fin) begin
        done_n = 1'b1;  len_n = nb;  st_n = S_PFX;  cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q <= S_PFX;  cnt_q <= '0;  fc_q <= '0;  len_q <= '0;  map_q <= '0;
      osz_q <= 1'b0;  asz_q <= 1'b0;  ws_q <= 1'b0;  wp_q <= '0;  opc_q <= '0;
      fs_q <= 1'b0;  form_q <= '0;  ss_q <= 1'b0;  sxb_q <= '0;  r0_q <= 1'b0;
      dl_q <= '0;  disp_q <= '0;  il_q <= '0;  imm_q <= '0;  ipr_q <= 1'b0;
      rdy_q <= 1'b0;  done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      rdy_q  <= 1'b1;
      done_q <= done_n;
      err_q  <= err_n;
      if (acc) begin
        st_q <= st_n;  cnt_q <= cnt_n;  fc_q <= fc_n;  len_q <= len_n;  map_q <= map_n;
        osz_q <= osz_n;  asz_q <= asz_n;  ws_q <= ws_n;  wp_q <= wp_n;  opc_q <= opc_n;
        fs_q <= fs_n;  form_q <= form_n;  ss_q <= ss_n;  sxb_q <= sxb_n;  r0_q <= r0_n;
        dl_q <= dl_n;  disp_q <= disp_n;  il_q <= il_n;  imm_q <= imm_n;  ipr_q <= ipr_n;
      end
    end
  end

  assign in_ready = rdy_q;   assign done = done_q;     assign err = err_q;
  assign len = len_q;        assign map = map_q;       assign osz = osz_q;
  assign asz = asz_q;        assign wpfx_seen = ws_q;  assign wpfx = wp_q;
  assign opcode = opc_q;     assign form_seen = fs_q;  assign form = form_q;
  assign sxb_seen = ss_q;    assign sxb = sxb_q;       assign disp_len = dl_q;
  assign disp = disp_q;      assign imm_len = il_q;    assign imm = imm_q;
  assign ip_rel = ipr_q;
endmodule

// File: rtl/ibyte_parser_chk.sv
module ibyte_parser_chk #(
  parameter int MAX_LEN = 15,
  parameter int LW = 4,
  parameter int DLW = 3,
  parameter int DW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode64,
  input logic           in_valid,
  input logic           in_ready,
  input logic           done,
  input logic           err,
  input logic [LW-1:0]  len,
  input logic [1:0]     map,
  input logic           osz,
  input logic           wpfx_seen,
  input logic [3:0]     wpfx,
  input logic [7:0]     opcode,
  input logic           form_seen,
  input logic [7:0]     form,
  input logic           sxb_seen,
  input logic [DLW-1:0] disp_len,
  input logic [DW-1:0]  disp,
  input logic [DLW-1:0] imm_len,
  input logic [DW-1:0]  imm,
  input logic           ip_rel
);
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_len_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (len != '0 && len <= LW'(MAX_LEN)));
  p_wpfx_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wpfx_seen) |-> mode64);
  p_map_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && map != 2'd0) |-> len >= LW'(2));
  p_sxb_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sxb_seen) |-> (form_seen && form[7:6] != 2'b11 && form[2:0] == 3'b100));
  p_disp8_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && form_seen && form[7:6] == 2'b01) |-> disp_len == DLW'(1));
  p_iprel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ip_rel) |-> (mode64 && form[7:6] == 2'b00 && form[2:0] == 3'b101));
  p_imm16_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && imm_len == DLW'(2)) |-> (osz && !(wpfx_seen && wpfx[3])));
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(in_ready));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable({opcode, form, disp, imm, len}));
endmodule

bind ibyte_parser ibyte_parser_chk #(.MAX_LEN(MAX_LEN), .LW(LW), .DLW(DLW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .err(err), .len(len), .map(map), .osz(osz), .wpfx_seen(wpfx_seen),
  .wpfx(wpfx), .opcode(opcode), .form_seen(form_seen), .form(form), .sxb_seen(sxb_seen),
  .disp_len(disp_len), .disp(disp), .imm_len(imm_len), .imm(imm), .ip_rel(ip_rel)
);

// File: tb/ibyte_parser_bench.sv
module ibyte_parser_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, mode64, in_valid, in_ready, done, err;
  logic [7:0] in_byte;
  logic [3:0] len, wpfx;
  logic [1:0] map;
  logic osz, asz, wpfx_seen, form_seen, sxb_seen, ip_rel;
  logic [7:0] opcode, form, sxb;
  logic [2:0] disp_len, imm_len;
  logic [31:0] disp, imm;

  ibyte_parser u_ibyte_parser (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .done(done), .err(err), .len(len), .map(map), .osz(osz),
    .asz(asz), .wpfx_seen(wpfx_seen), .wpfx(wpfx), .opcode(opcode),
    .form_seen(form_seen), .form(form), .sxb_seen(sxb_seen), .sxb(sxb),
    .disp_len(disp_len), .disp(disp), .imm_len(imm_len), .imm(imm), .ip_rel(ip_rel)
  );

  typedef struct packed {
    logic is_err; logic [3:0] len; logic [1:0] map; logic osz, asz, ws; logic [3:0] wp;
    logic [7:0] opc; logic fs; logic [7:0] form; logic ss; logic [7:0] sxb;
    logic [2:0] dl; logic [31:0] disp; logic [2:0] il; logic [31:0] imm; logic ipr;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  logic [7:0] bq[$];
  int total = 0, bad = 0;
  logic mon_on = 1'b0;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input string tag, input exp_t e);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic send(input int gap);
    foreach (bq[i]) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = bq[i];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (in_ready !== 1'b1) begin
        total++; bad++;
        $display("FAIL R11 in_ready actual=%b expected=1", in_ready);
      end
      if (done === 1'b1 || err === 1'b1) begin
        exp_t a, e;
        string t;
        a = '{is_err: err, len: len, map: map, osz: osz, asz: asz, ws: wpfx_seen, wp: wpfx,
              opc: opcode, fs: form_seen, form: form, ss: sxb_seen, sxb: sxb, dl: disp_len,
              disp: disp, il: imm_len, imm: imm, ipr: ip_rel};
        if (done === err) a.is_err = 1'bx;
        if (expq.size() == 0) begin
          total++; bad++;
          $display("FAIL R7 unexpected result actual=%h expected=none", a);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          if (e.is_err) begin
            exp_t m;
            m = '0;
            m.is_err = a.is_err;
            m.len    = a.len;
            a = m;
          end
          check(t, 128'(a), 128'(e));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    exp_t e;
    rst_n = 1'b0; mode64 = 1'b0; in_valid = 1'b0; in_byte = '0;
    repeat (3) @(negedge clk);
    check("R12 reset outputs", 128'({done, err, in_ready}), 128'(3'b000));
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after release", 128'({done, err}), 128'(2'b00));
    repeat (3) @(negedge clk);
    check("R11 ready after reset", 128'(in_ready), 128'(1'b1));
    mon_on = 1'b1;

    // R1 R6: operand-size prefix, byte immediate
    e = '0; e.len = 4; e.osz = 1; e.opc = 8'h83; e.fs = 1; e.form = 8'hC3; e.il = 1; e.imm = 32'h01;
    expect_item("R1 R6 prefixed byte-imm", e);
    bq = '{8'h66, 8'h83, 8'hC3, 8'h01}; send(0);
    idle(4);
    check("R7 fields held after done", 128'({opcode, imm, len}), 128'({8'h83, 32'h01, 4'd4}));

    // R4 R5 R6: scaled-index byte, 1-byte disp, 4-byte imm
    e = '0; e.len = 8; e.opc = 8'hC7; e.fs = 1; e.form = 8'h44; e.ss = 1; e.sxb = 8'h98;
    e.dl = 1; e.disp = 32'h10; e.il = 4; e.imm = 32'h0000_4000;
    expect_item("R4 R5 sxb disp8 imm32", e);
    bq = '{8'hC7, 8'h44, 8'h98, 8'h10, 8'h00, 8'h40, 8'h00, 8'h00}; send(0);

    // R4 mode00 sxb base not 101, R5 mode10, R5 base101, R5 low101 outside 64-bit
    e = '0; e.len = 3; e.opc = 8'h8B; e.fs = 1; e.form = 8'h04; e.ss = 1; e.sxb = 8'h98;
    expect_item("R4 sxb no disp", e);
    bq = '{8'h8B, 8'h04, 8'h98}; send(0);
    e = '0; e.len = 7; e.opc = 8'h8B; e.fs = 1; e.form = 8'h04; e.ss = 1; e.sxb = 8'h25;
    e.dl = 4; e.disp = 32'h1234_5678;
    expect_item("R5 sxb base101 disp32", e);
    bq = '{8'h8B, 8'h04, 8'h25, 8'h78, 8'h56, 8'h34, 8'h12}; send(0);
    e = '0; e.len = 6; e.opc = 8'h89; e.fs = 1; e.form = 8'h80; e.dl = 4; e.disp = 32'h0403_0201;
    expect_item("R5 mode10 disp32", e);
    bq = '{8'h89, 8'h80, 8'h01, 8'h02, 8'h03, 8'h04}; send(0);
    e = '0; e.len = 6; e.opc = 8'h8B; e.fs = 1; e.form = 8'h05; e.dl = 4; e.disp = 32'h1;
    expect_item("R5 low101 not ip-relative in 32-bit", e);
    bq = '{8'h8B, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00}; send(0);

    // R3 maps
    e = '0; e.len = 3; e.map = 1; e.opc = 8'hAF; e.fs = 1; e.form = 8'hC8;
    expect_item("R3 map1", e);
    bq = '{8'h0F, 8'hAF, 8'hC8}; send(0);
    e = '0; e.len = 4; e.map = 2; e.opc = 8'h00; e.fs = 1; e.form = 8'hC1;
    expect_item("R3 map2", e);
    bq = '{8'h0F, 8'h38, 8'h00, 8'hC1}; send(0);
    e = '0; e.len = 6; e.map = 3; e.osz = 1; e.opc = 8'h0F; e.fs = 1; e.form = 8'hC1; e.il = 1; e.imm = 32'h08;
    expect_item("R3 map3 byte imm", e);
    bq = '{8'h66, 8'h0F, 8'h3A, 8'h0F, 8'hC1, 8'h08}; send(0);

    // R2 outside 64-bit: 0x48 is an opcode; R1 both prefixes
    e = '0; e.len = 1; e.opc = 8'h48;
    expect_item("R2 0x48 opcode in 32-bit", e);
    bq = '{8'h48}; send(0);
    e = '0; e.len = 3; e.osz = 1; e.asz = 1; e.opc = 8'h90;
    expect_item("R1 both prefixes", e);
    bq = '{8'h66, 8'h67, 8'h90}; send(0);
    e = '0; e.len = 4; e.osz = 1; e.opc = 8'h05; e.il = 2; e.imm = 32'h1234;
    expect_item("R6 size imm 16-bit", e);
    bq = '{8'h66, 8'h05, 8'h34, 8'h12}; send(0);

    // R8 unknown opcodes then resync
    e = '0; e.is_err = 1; e.len = 2;
    expect_item("R8 unknown map1 opcode", e);
    bq = '{8'h0F, 8'h0B}; send(0);
    e = '0; e.len = 1; e.opc = 8'h90;
    expect_item("R8 resync after error", e);
    bq = '{8'h90}; send(0);
    e = '0; e.is_err = 1; e.len = 1;
    expect_item("R8 unknown map0 opcode", e);
    bq = '{8'hD6}; send(0);

    // R9 middle field check
    e = '0; e.is_err = 1; e.len = 2;
    expect_item("R9 0xC7 middle field", e);
    bq = '{8'hC7, 8'hC8}; send(0);
    e = '0; e.len = 1; e.opc = 8'hC3;
    expect_item("R9 resync", e);
    bq = '{8'hC3}; send(0);

    // R10 length limit
    e = '0; e.is_err = 1; e.len = 15;
    expect_item("R10 fifteen prefixes", e);
    bq.delete(); for (int i = 0; i < 15; i++) bq.push_back(8'h66); send(0);
    e = '0; e.len = 15; e.osz = 1; e.opc = 8'hC7; e.fs = 1; e.form = 8'hC0; e.il = 2; e.imm = 32'h1234;
    expect_item("R10 exactly fifteen bytes", e);
    bq.delete(); for (int i = 0; i < 11; i++) bq.push_back(8'h66);
    bq.push_back(8'hC7); bq.push_back(8'hC0); bq.push_back(8'h34); bq.push_back(8'h12); send(0);

    // R11 stalls between bytes
    e = '0; e.len = 3; e.opc = 8'h83; e.fs = 1; e.form = 8'hC3; e.il = 1; e.imm = 32'h05;
    expect_item("R11 stalled input", e);
    bq = '{8'h83, 8'hC3, 8'h05}; send(2);
    idle(2);

    // 64-bit mode
    mode64 = 1'b1;
    e = '0; e.len = 9; e.ws = 1; e.wp = 4'h8; e.opc = 8'hC7; e.fs = 1; e.form = 8'h44; e.ss = 1;
    e.sxb = 8'h98; e.dl = 1; e.disp = 32'h10; e.il = 4; e.imm = 32'h0000_0400;
    expect_item("R2 width prefix W", e);
    bq = '{8'h48, 8'hC7, 8'h44, 8'h98, 8'h10, 8'h00, 8'h04, 8'h00, 8'h00}; send(0);
    e = '0; e.len = 7; e.ws = 1; e.wp = 4'h8; e.opc = 8'h8B; e.fs = 1; e.form = 8'h15;
    e.dl = 4; e.disp = 32'h1234_5678; e.ipr = 1;
    expect_item("R5 ip-relative", e);
    bq = '{8'h48, 8'h8B, 8'h15, 8'h78, 8'h56, 8'h34, 8'h12}; send(0);
    e = '0; e.len = 4; e.ws = 1; e.wp = 4'h9; e.opc = 8'h8B; e.fs = 1; e.form = 8'h55; e.dl = 1;
    expect_item("R5 mode01 low101 disp8", e);
    bq = '{8'h49, 8'h8B, 8'h55, 8'h00}; send(0);
    e = '0; e.len = 7; e.osz = 1; e.ws = 1; e.wp = 4'h8; e.opc = 8'h05; e.il = 4; e.imm = 32'h4433_2211;
    expect_item("R6 W overrides size prefix", e);
    bq = '{8'h66, 8'h48, 8'h05, 8'h11, 8'h22, 8'h33, 8'h44}; send(0);
    e = '0; e.len = 2; e.ws = 1; e.wp = 4'h0; e.opc = 8'h90;
    expect_item("R2 empty width prefix", e);
    bq = '{8'h40, 8'h90}; send(0);
    e = '0; e.len = 2; e.opc = 8'h6A; e.il = 1; e.imm = 32'h7F;
    expect_item("R13 byte imm no form", e);
    bq = '{8'h6A, 8'h7F}; send(0);

    idle(6);
    check("R7 all results seen", 128'(expq.size()), 128'(0));
    finish_up();
  end
endmodule